// File: doc/BRIEF.md
# Wide-Register Integer Execute Unit

This block is the integer execute stage of a core whose general registers are 128 bits wide. Each cycle it takes one 32-bit instruction word and the two source register values, decodes the word, and one clock later presents the result, a write-enable for the destination register, and a flag that marks words it does not recognise. It has no pipeline handshake: every rising edge it captures whatever instruction sits on its inputs.

Three operand widths are supported. Full-width operations use all 128 bits: add, subtract, add-immediate, the three logical operations, the signed and unsigned set-less-than, and the three shifts. Double-width operations have their own major opcodes. They compute on the low 64 bits and copy bit 63 of the result into the upper half. Word operations compute on the low 32 bits and copy bit 31 into all upper bits. The 12-bit immediate of an I-type word is always sign-extended over the whole register before use.

Top module: `rv_wide_alu`

## Requirements
- R1: While rst_n is low, res_o, wen_o and illegal_o are all zero.
- R2: Outputs are registered. The result for the instruction present at a rising edge appears after that edge and holds until the next edge.
- R3: Full add and subtract work over 128 bits, so a carry or borrow crosses from bit 63 into bit 64. Add-immediate (opcode 0010011, funct3 000) adds the immediate sign-extended from instruction bit 31.
- R4: XOR, OR and AND are available as register forms (opcode 0110011, funct3 100/110/111, funct7 0) and as immediate forms (opcode 0010011). The sign-extended immediate also acts on the upper 64 bits.
- R5: Signed and unsigned set-less-than (funct3 010 and 011, register and immediate forms) compare all 128 bits and return 0 or 1.
- R6: Full shifts take their amount from rs2 bits 6:0, or from instruction bits 26:20. Immediate shifts need bits 31:27 equal to 00000, or 01000 for an arithmetic right shift. funct3 001 is a left shift and 101 a right shift.
- R7: Opcode 1011011 holds the immediate double-width operations. funct3 000 is an add. funct3 001 with bits 31:26 = 000000 is a left shift. funct3 101 with bits 31:26 = 000000 or 010000 is a logical or arithmetic right shift by bits 25:20.
- R8: Opcode 1111011 holds the register double-width operations. funct3 000 is an add with funct7 0000000 and a subtract with funct7 0100000. funct3 001 with funct7 0 is a left shift. funct3 101 with funct7 0000000 or 0100000 is a logical or arithmetic right shift. The shift amount is rs2 bits 5:0.
- R9: Every double-width result is formed from the low 64 bits and sign-extended from bit 63 to 128 bits.
- R10: Word operations (opcode 0111011: add, sub, sll, srl, sra; opcode 0011011: add-immediate and the three immediate shifts with bits 31:25 = 0000000 or 0100000) produce a 32-bit result that is sign-extended from bit 31. The shift amount is 5 bits.
- R11: A destination field (bits 11:7) of zero drives wen_o low.
- R12: A word that matches no supported combination of opcode, funct3 and upper bits sets illegal_o, clears wen_o and drives res_o to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_i | input | 32 | Instruction word |
| rs1_val_i | input | 128 | First source register value |
| rs2_val_i | input | 128 | Second source register value |
| res_o | output | 128 | Registered result |
| wen_o | output | 1 | Registered destination write-enable |
| illegal_o | output | 1 | Registered unrecognised-instruction flag |

## Verification
The bench builds the block with its default register width of 128, which fixes the double width at 64 and the word width at 32. This makes the three real boundaries reachable: a carry crossing bit 63, shift amounts of 64 and 127, and sign extension from bits 31 and 63. Directed words cover each opcode group at these edges. A random stream over all six major opcodes, with random upper bits, also exercises the illegal combinations.

// File: rtl/rv_wide_alu_pkg.sv
`timescale 1ns/1ps
package rv_wide_alu_pkg;

    localparam logic [6:0] OPC_OP      = 7'b0110011;
    localparam logic [6:0] OPC_IMM     = 7'b0010011;
    localparam logic [6:0] OPC_OP_W    = 7'b0111011;
    localparam logic [6:0] OPC_IMM_W   = 7'b0011011;
    localparam logic [6:0] OPC_OP_D    = 7'b1111011;
    localparam logic [6:0] OPC_IMM_D   = 7'b1011011;

    localparam logic [6:0] F7_BASE     = 7'b0000000;
    localparam logic [6:0] F7_ALT      = 7'b0100000;

    typedef enum logic [3:0] {
        OP_ADD, OP_SUB, OP_SLL, OP_SRL, OP_SRA,
        OP_SLT, OP_SLTU, OP_XOR, OP_OR, OP_AND
    } alu_op_e;

    typedef enum logic [1:0] {
        WID_FULL, WID_DBL, WID_WORD
    } wid_e;

    typedef struct packed {
        alu_op_e op;
        wid_e    wid;
        logic    use_imm;
        logic    legal;
    } alu_ctrl_t;

endpackage

// File: rtl/rv_wide_alu_dec.sv
`timescale 1ns/1ps
module rv_wide_alu_dec
    import rv_wide_alu_pkg::*;
(
    input  logic [6:0] opc_i,
    input  logic [2:0] f3_i,
    input  logic [6:0] hi_i,     // instruction bits 31:25
    input  logic       b25_i,    // instruction bit 25 (shamt bit 5 of D shifts)
    output alu_ctrl_t  ctrl_o
);
    logic f7_base, f7_alt;
    logic sh7_base, sh7_alt;   // bits 31:27 for full immediate shifts
    logic sh6_base, sh6_alt;   // bits 31:26 for double immediate shifts
    logic unused_b25;

    assign f7_base  = (hi_i == F7_BASE);
    assign f7_alt   = (hi_i == F7_ALT);
    assign sh7_base = (hi_i[6:2] == 5'b00000);
    assign sh7_alt  = (hi_i[6:2] == 5'b01000);
    assign sh6_base = (hi_i[6:1] == 6'b000000);
    assign sh6_alt  = (hi_i[6:1] == 6'b010000);
    assign unused_b25 = b25_i;

    always_comb begin
        ctrl_o = '{op: OP_ADD, wid: WID_FULL, use_imm: 1'b0, legal: 1'b0};
        case (opc_i)
            OPC_OP: begin
                case (f3_i)
                    3'b000: begin
                        ctrl_o.legal = f7_base | f7_alt;
                        ctrl_o.op    = f7_alt ? OP_SUB : OP_ADD;
                    end
                    3'b001: begin ctrl_o.legal = f7_base; ctrl_o.op = OP_SLL;  end
                    3'b010: begin ctrl_o.legal = f7_base; ctrl_o.op = OP_SLT;  end
                    3'b011: begin ctrl_o.legal = f7_base; ctrl_o.op = OP_SLTU; end
                    3'b100: begin ctrl_o.legal = f7_base; ctrl_o.op = OP_XOR;  end
                    3'b101: begin
                        ctrl_o.legal = f7_base | f7_alt;
                        ctrl_o.op    = f7_alt ? OP_SRA : OP_SRL;
                    end
                    3'b110: begin ctrl_o.legal = f7_base; ctrl_o.op = OP_OR;   end
                    default: begin ctrl_o.legal = f7_base; ctrl_o.op = OP_AND; end
                endcase
            end
            OPC_IMM: begin
                ctrl_o.use_imm = 1'b1;
                case (f3_i)
                    3'b000: begin ctrl_o.legal = 1'b1; ctrl_o.op = OP_ADD;  end
                    3'b001: begin ctrl_o.legal = sh7_base; ctrl_o.op = OP_SLL; end
                    3'b010: begin ctrl_o.legal = 1'b1; ctrl_o.op = OP_SLT;  end
                    3'b011: begin ctrl_o.legal = 1'b1; ctrl_o.op = OP_SLTU; end
                    3'b100: begin ctrl_o.legal = 1'b1; ctrl_o.op = OP_XOR;  end
                    3'b101: begin
                        ctrl_o.legal = sh7_base | sh7_alt;
                        ctrl_o.op    = sh7_alt ? OP_SRA : OP_SRL;
                    end
                    3'b110: begin ctrl_o.legal = 1'b1; ctrl_o.op = OP_OR;   end
                    default: begin ctrl_o.legal = 1'b1; ctrl_o.op = OP_AND; end
                endcase
            end
            OPC_OP_W, OPC_OP_D: begin
                ctrl_o.wid = (opc_i == OPC_OP_W) ? WID_WORD : WID_DBL;
                case (f3_i)
                    3'b000: begin
                        ctrl_o.legal = f7_base | f7_alt;
                        ctrl_o.op    = f7_alt ? OP_SUB : OP_ADD;
                    end
                    3'b001: begin ctrl_o.legal = f7_base; ctrl_o.op = OP_SLL; end
                    3'b101: begin
                        ctrl_o.legal = f7_base | f7_alt;
                        ctrl_o.op    = f7_alt ? OP_SRA : OP_SRL;
                    end
                    default: ctrl_o.legal = 1'b0;
                endcase
            end
            OPC_IMM_W: begin
                ctrl_o.wid     = WID_WORD;
                ctrl_o.use_imm = 1'b1;
                case (f3_i)
                    3'b000: begin ctrl_o.legal = 1'b1; ctrl_o.op = OP_ADD; end
                    3'b001: begin ctrl_o.legal = f7_base; ctrl_o.op = OP_SLL; end
                    3'b101: begin
                        ctrl_o.legal = f7_base | f7_alt;
                        ctrl_o.op    = f7_alt ? OP_SRA : OP_SRL;
                    end
                    default: ctrl_o.legal = 1'b0;
                endcase
            end
            OPC_IMM_D: begin
                ctrl_o.wid     = WID_DBL;
                ctrl_o.use_imm = 1'b1;
                case (f3_i)
                    3'b000: begin ctrl_o.legal = 1'b1; ctrl_o.op = OP_ADD; end
                    3'b001: begin ctrl_o.legal = sh6_base; ctrl_o.op = OP_SLL; end
                    3'b101: begin
                        ctrl_o.legal = sh6_base | sh6_alt;
                        ctrl_o.op    = sh6_alt ? OP_SRA : OP_SRL;
                    end
                    default: ctrl_o.legal = 1'b0;
                endcase
            end
            default: ctrl_o.legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/rv_wide_alu_shift.sv
`timescale 1ns/1ps
module rv_wide_alu_shift
    import rv_wide_alu_pkg::*;
#(
    parameter int XLEN = 128
) (
    input  logic [XLEN-1:0]         val_i,
    input  logic [$clog2(XLEN)-1:0] amt_i,
    input  alu_op_e                 op_i,
    input  wid_e                    wid_i,
    output logic [XLEN-1:0]         res_o
);
    localparam int SHW = $clog2(XLEN);
    localparam int DW  = XLEN / 2;
    localparam int WW  = XLEN / 4;

    logic [SHW-1:0]  amt_m;
    logic [XLEN-1:0] src_z;
    logic [XLEN-1:0] src_s;

    always_comb begin
        case (wid_i)
            WID_WORD: begin
                amt_m = amt_i & SHW'(WW - 1);
                src_z = {{(XLEN-WW){1'b0}}, val_i[WW-1:0]};
                src_s = {{(XLEN-WW){val_i[WW-1]}}, val_i[WW-1:0]};
            end
            WID_DBL: begin
                amt_m = amt_i & SHW'(DW - 1);
                src_z = {{(XLEN-DW){1'b0}}, val_i[DW-1:0]};
                src_s = {{(XLEN-DW){val_i[DW-1]}}, val_i[DW-1:0]};
            end
            default: begin
                amt_m = amt_i;
                src_z = val_i;
                src_s = val_i;
            end
        endcase
        case (op_i)
            OP_SLL:  res_o = val_i << amt_m;
            OP_SRL:  res_o = src_z >> amt_m;
            OP_SRA:  res_o = XLEN'($signed(src_s) >>> amt_m);
            default: res_o = '0;
        endcase
    end

endmodule

// File: rtl/rv_wide_alu_cmp.sv
`timescale 1ns/1ps
module rv_wide_alu_cmp #(
    parameter int XLEN = 128
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic            signed_i,
    output logic            lt_o
);
    logic sign_differs;

    // Differing sign bits decide a signed compare; otherwise magnitude does.
    assign sign_differs = a_i[XLEN-1] ^ b_i[XLEN-1];
    assign lt_o = (signed_i && sign_differs) ? a_i[XLEN-1] : (a_i < b_i);

endmodule

// File: rtl/rv_wide_alu.sv
`timescale 1ns/1ps
module rv_wide_alu
    import rv_wide_alu_pkg::*;
#(
    parameter int XLEN = 128
) (
    input  logic            clk_i,
    input  logic            rst_n,
    input  logic [31:0]     insn_i,
    input  logic [XLEN-1:0] rs1_val_i,
    input  logic [XLEN-1:0] rs2_val_i,
    output logic [XLEN-1:0] res_o,
    output logic            wen_o,
    output logic            illegal_o
);
    localparam int SHW = $clog2(XLEN);
    localparam int DW  = XLEN / 2;
    localparam int WW  = XLEN / 4;
    localparam int IMW = 12;

    typedef struct packed {
        logic [XLEN-1:0] res;
        logic            wen;
        logic            illegal;
    } out_t;

    out_t            out_d, out_q;
    alu_ctrl_t       ctrl;
    logic [XLEN-1:0] imm_x;
    logic [XLEN-1:0] opb;
    logic [XLEN-1:0] shift_res;
    logic            lt;
    logic [XLEN-1:0] raw;
    logic [XLEN-1:0] sized;
    logic            unused_rs1_idx;

    assign unused_rs1_idx = ^insn_i[19:15];

    rv_wide_alu_dec u_dec (
        .opc_i  (insn_i[6:0]),
        .f3_i   (insn_i[14:12]),
        .hi_i   (insn_i[31:25]),
        .b25_i  (insn_i[25]),
        .ctrl_o (ctrl)
    );

    assign imm_x = {{(XLEN-IMW){insn_i[31]}}, insn_i[31:20]};
    assign opb   = ctrl.use_imm ? imm_x : rs2_val_i;

    rv_wide_alu_shift #(.XLEN(XLEN)) u_shift (
        .val_i (rs1_val_i),
        .amt_i (opb[SHW-1:0]),
        .op_i  (ctrl.op),
        .wid_i (ctrl.wid),
        .res_o (shift_res)
    );

    rv_wide_alu_cmp #(.XLEN(XLEN)) u_cmp (
        .a_i      (rs1_val_i),
        .b_i      (opb),
        .signed_i (ctrl.op == OP_SLT),
        .lt_o     (lt)
    );

    always_comb begin
        case (ctrl.op)
            OP_ADD:  raw = rs1_val_i + opb;
            OP_SUB:  raw = rs1_val_i - opb;
            OP_XOR:  raw = rs1_val_i ^ opb;
            OP_OR:   raw = rs1_val_i | opb;
            OP_AND:  raw = rs1_val_i & opb;
            OP_SLT,
            OP_SLTU: raw = {{(XLEN-1){1'b0}}, lt};
            default: raw = shift_res;
        endcase

        case (ctrl.wid)
            WID_WORD: sized = {{(XLEN-WW){raw[WW-1]}}, raw[WW-1:0]};
            WID_DBL:  sized = {{(XLEN-DW){raw[DW-1]}}, raw[DW-1:0]};
            default:  sized = raw;
        endcase

        out_d.illegal = ~ctrl.legal;
        out_d.wen     = ctrl.legal && (insn_i[11:7] != 5'd0);
        out_d.res     = ctrl.legal ? sized : '0;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign res_o     = out_q.res;
    assign wen_o     = out_q.wen;
    assign illegal_o = out_q.illegal;

endmodule

// File: rtl/rv_wide_alu_chk.sv
`timescale 1ns/1ps
module rv_wide_alu_chk #(
    parameter int XLEN = 128
) (
    input logic            clk_i,
    input logic            rst_n,
    input logic [31:0]     insn_i,
    input logic [XLEN-1:0] rs1_val_i,
    input logic [XLEN-1:0] rs2_val_i,
    input logic [XLEN-1:0] res_o,
    input logic            wen_o,
    input logic            illegal_o
);
    localparam int DW = XLEN / 2;
    localparam int WW = XLEN / 4;

    logic unused_fields;
    assign unused_fields = ^insn_i[24:15];

    AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_n)
        illegal_o |-> (!wen_o && res_o == '0)); // R12

    AST_RD_ZERO_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_n)
        (insn_i[11:7] == 5'd0) |=> !wen_o); // R11

    AST_WORD_SIGN_EXT: assert property (@(posedge clk_i) disable iff (!rst_n)
        (wen_o && ($past(insn_i[6:0]) == 7'b0111011 || $past(insn_i[6:0]) == 7'b0011011))
        |-> (res_o[XLEN-1:WW-1] == '0 || (&res_o[XLEN-1:WW-1]))); // R10

    AST_DBL_SIGN_EXT: assert property (@(posedge clk_i) disable iff (!rst_n)
        (wen_o && ($past(insn_i[6:0]) == 7'b1111011 || $past(insn_i[6:0]) == 7'b1011011))
        |-> (res_o[XLEN-1:DW-1] == '0 || (&res_o[XLEN-1:DW-1]))); // R9

    AST_FULL_ADD_CARRY: assert property (@(posedge clk_i) disable iff (!rst_n)
        (wen_o && $past(insn_i[6:0]) == 7'b0110011 && $past(insn_i[31:25]) == 7'd0
               && $past(insn_i[14:12]) == 3'b000)
        |-> (res_o == $past(rs1_val_i) + $past(rs2_val_i))); // R3

    AST_SET_LESS_BOOL: assert property (@(posedge clk_i) disable iff (!rst_n)
        (wen_o && ($past(insn_i[6:0]) == 7'b0110011 || $past(insn_i[6:0]) == 7'b0010011)
               && $past(insn_i[14:13]) == 2'b01)
        |-> (res_o[XLEN-1:1] == '0)); // R5

endmodule

bind rv_wide_alu rv_wide_alu_chk #(.XLEN(XLEN)) u_chk (
    .clk_i     (clk_i),
    .rst_n     (rst_n),
    .insn_i    (insn_i),
    .rs1_val_i (rs1_val_i),
    .rs2_val_i (rs2_val_i),
    .res_o     (res_o),
    .wen_o     (wen_o),
    .illegal_o (illegal_o)
);

// File: tb/rv_wide_alu_tb_top.sv
`timescale 1ns/1ps
module rv_wide_alu_tb_top;

    logic         clk_i = 1'b0;
    logic         rst_n = 1'b0;
    logic [31:0]  insn_i = '0;
    logic [127:0] rs1_val_i = '0;
    logic [127:0] rs2_val_i = '0;
    logic [127:0] res_o;
    logic         wen_o;
    logic         illegal_o;

    int compared   = 0;
    int mismatched = 0;
    bit done       = 1'b0;

    always #5 clk_i = ~clk_i;

    rv_wide_alu #(.XLEN(128)) dut_i (
        .clk_i     (clk_i),
        .rst_n     (rst_n),
        .insn_i    (insn_i),
        .rs1_val_i (rs1_val_i),
        .rs2_val_i (rs2_val_i),
        .res_o     (res_o),
        .wen_o     (wen_o),
        .illegal_o (illegal_o)
    );

    function automatic logic [31:0] rtype(input logic [6:0] f7, input logic [2:0] f3,
                                          input logic [4:0] rd, input logic [6:0] opc);
        return {f7, 5'd2, 5'd1, f3, rd, opc};
    endfunction

    function automatic logic [31:0] itype(input logic [11:0] imm, input logic [2:0] f3,
                                          input logic [4:0] rd, input logic [6:0] opc);
        return {imm, 5'd1, f3, rd, opc};
    endfunction

    function automatic logic [127:0] sx32(input logic [31:0] v);
        return {{96{v[31]}}, v};
    endfunction

    function automatic logic [127:0] sx64(input logic [63:0] v);
        return {{64{v[63]}}, v};
    endfunction

    // Behavioural reference of one instruction.
    function automatic void model(input logic [31:0] i, input logic [127:0] a,
                                  input logic [127:0] b, output logic [127:0] r,
                                  output logic w, output logic il);
        logic [6:0]   opc = i[6:0];
        logic [2:0]   f3  = i[14:12];
        logic [6:0]   f7  = i[31:25];
        logic [127:0] imm = {{116{i[31]}}, i[31:20]};
        logic [31:0]  wa  = a[31:0];
        logic [63:0]  da  = a[63:0];
        il = 1'b0;
        r  = '0;
        case (opc)
            7'b0110011: begin
                if (f7 == 7'h00) begin
                    case (f3)
                        3'd0: r = a + b;
                        3'd1: r = a << b[6:0];
                        3'd2: r = {127'd0, $signed(a) < $signed(b)};
                        3'd3: r = {127'd0, a < b};
                        3'd4: r = a ^ b;
                        3'd5: r = a >> b[6:0];
                        3'd6: r = a | b;
                        default: r = a & b;
                    endcase
                end else if (f7 == 7'h20 && f3 == 3'd0) r = a - b;
                else if (f7 == 7'h20 && f3 == 3'd5) r = $signed(a) >>> b[6:0];
                else il = 1'b1;
            end
            7'b0010011: begin
                case (f3)
                    3'd0: r = a + imm;
                    3'd2: r = {127'd0, $signed(a) < $signed(imm)};
                    3'd3: r = {127'd0, a < imm};
                    3'd4: r = a ^ imm;
                    3'd6: r = a | imm;
                    3'd7: r = a & imm;
                    3'd1: if (i[31:27] == 5'b00000) r = a << i[26:20]; else il = 1'b1;
                    default: begin
                        if (i[31:27] == 5'b00000) r = a >> i[26:20];
                        else if (i[31:27] == 5'b01000) r = $signed(a) >>> i[26:20];
                        else il = 1'b1;
                    end
                endcase
            end
            7'b0111011: begin
                if (f3 == 3'd0 && f7 == 7'h00) r = sx32(wa + b[31:0]);
                else if (f3 == 3'd0 && f7 == 7'h20) r = sx32(wa - b[31:0]);
                else if (f3 == 3'd1 && f7 == 7'h00) r = sx32(wa << b[4:0]);
                else if (f3 == 3'd5 && f7 == 7'h00) r = sx32(wa >> b[4:0]);
                else if (f3 == 3'd5 && f7 == 7'h20) r = sx32($signed(wa) >>> b[4:0]);
                else il = 1'b1;
            end
            7'b0011011: begin
                if (f3 == 3'd0) r = sx32(wa + imm[31:0]);
                else if (f3 == 3'd1 && f7 == 7'h00) r = sx32(wa << i[24:20]);
                else if (f3 == 3'd5 && f7 == 7'h00) r = sx32(wa >> i[24:20]);
                else if (f3 == 3'd5 && f7 == 7'h20) r = sx32($signed(wa) >>> i[24:20]);
                else il = 1'b1;
            end
            7'b1111011: begin
                if (f3 == 3'd0 && f7 == 7'h00) r = sx64(da + b[63:0]);
                else if (f3 == 3'd0 && f7 == 7'h20) r = sx64(da - b[63:0]);
                else if (f3 == 3'd1 && f7 == 7'h00) r = sx64(da << b[5:0]);
                else if (f3 == 3'd5 && f7 == 7'h00) r = sx64(da >> b[5:0]);
                else if (f3 == 3'd5 && f7 == 7'h20) r = sx64($signed(da) >>> b[5:0]);
                else il = 1'b1;
            end
            7'b1011011: begin
                if (f3 == 3'd0) r = sx64(da + imm[63:0]);
                else if (f3 == 3'd1 && i[31:26] == 6'b000000) r = sx64(da << i[25:20]);
                else if (f3 == 3'd5 && i[31:26] == 6'b000000) r = sx64(da >> i[25:20]);
                else if (f3 == 3'd5 && i[31:26] == 6'b010000) r = sx64($signed(da) >>> i[25:20]);
                else il = 1'b1;
            end
            default: il = 1'b1;
        endcase
        w = !il && (i[11:7] != 5'd0);
    endfunction

    task automatic report(input string tag, input logic [127:0] er,
                          input logic ew, input logic eil, input bit cmp_res);
        compared++;
        if (wen_o !== ew || illegal_o !== eil || (cmp_res && res_o !== er)) begin
            mismatched++;
            $display("FAIL %s: res=%h exp=%h wen=%b exp=%b illegal=%b exp=%b",
                     tag, res_o, er, wen_o, ew, illegal_o, eil);
        end
    endtask

    task automatic run(input string tag, input logic [31:0] i,
                       input logic [127:0] a, input logic [127:0] b);
        logic [127:0] er;
        logic ew, eil;
        @(negedge clk_i);
        insn_i = i; rs1_val_i = a; rs2_val_i = b;
        model(i, a, b, er, ew, eil);
        @(posedge clk_i);
        #1;
        report(tag, er, ew, eil, ew || eil);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk_i);
        compared++;
        mismatched++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

    localparam logic [127:0] NEG  = {1'b1, 127'd5};
    localparam logic [127:0] LO1S = {64'd0, 64'hFFFF_FFFF_FFFF_FFFF};
    localparam logic [127:0] PAT  = 128'h8123_4567_89AB_CDEF_F0E1_D2C3_B4A5_9687;

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk_i);
        #1;
        report("R1", '0, 1'b0, 1'b0, 1'b1);
        @(negedge clk_i);
        rst_n = 1'b1;

        // R3: carry and borrow across the half boundary, add-immediate
        run("R3", rtype(7'h00, 3'd0, 5'd3, 7'b0110011), LO1S, 128'd1);
        run("R3", rtype(7'h20, 3'd0, 5'd3, 7'b0110011), {64'd1, 64'd0}, 128'd1);
        run("R3", itype(12'hFFF, 3'd0, 5'd3, 7'b0010011), 128'd0, 128'd0);

        // R2: output holds until the next edge
        @(negedge clk_i);
        insn_i = itype(12'h001, 3'd0, 5'd3, 7'b0010011);
        rs1_val_i = 128'd41;
        #2;
        report("R2", '1, 1'b1, 1'b0, 1'b1);
        @(posedge clk_i);
        #1;
        report("R2", 128'd42, 1'b1, 1'b0, 1'b1);

        // R4: logical ops, negative immediate reaches the upper half
        run("R4", itype(12'h800, 3'd4, 5'd4, 7'b0010011), PAT, 128'd0);
        run("R4", itype(12'h0F0, 3'd7, 5'd4, 7'b0010011), PAT, 128'd0);
        run("R4", itype(12'hF00, 3'd6, 5'd4, 7'b0010011), PAT, 128'd0);
        run("R4", rtype(7'h00, 3'd6, 5'd4, 7'b0110011), PAT, ~PAT);
        run("R4", rtype(7'h00, 3'd7, 5'd4, 7'b0110011), PAT, LO1S);

        // R5: signed vs unsigned compares over 128 bits
        run("R5", rtype(7'h00, 3'd2, 5'd5, 7'b0110011), NEG, 128'd7);
        run("R5", rtype(7'h00, 3'd3, 5'd5, 7'b0110011), NEG, 128'd7);
        run("R5", itype(12'hFFF, 3'd3, 5'd5, 7'b0010011), 128'd9, 128'd0);
        run("R5", itype(12'h010, 3'd2, 5'd5, 7'b0010011), {64'd1, 64'd0}, 128'd0);

        // R6: full-width shifts, amounts 64 and 127, rs2 masked to 7 bits
        run("R6", rtype(7'h00, 3'd1, 5'd6, 7'b0110011), PAT, 128'd64);
        run("R6", rtype(7'h00, 3'd5, 5'd6, 7'b0110011), PAT, 128'd131);
        run("R6", rtype(7'h20, 3'd5, 5'd6, 7'b0110011), PAT, 128'd127);
        run("R6", itype({5'b01000, 7'd127}, 3'd5, 5'd6, 7'b0010011), PAT, 128'd0);
        run("R6", itype({5'b00000, 7'd100}, 3'd1, 5'd6, 7'b0010011), PAT, 128'd0);

        // R7 / R9: immediate double-width ops
        run("R7", itype(12'h001, 3'd0, 5'd7, 7'b1011011), {64'hAA, 64'h7FFF_FFFF_FFFF_FFFF}, '0);
        run("R7", itype({6'b000000, 6'd63}, 3'd1, 5'd7, 7'b1011011), 128'd1, '0);
        run("R7", itype({6'b010000, 6'd10}, 3'd5, 5'd7, 7'b1011011), PAT, '0);
        run("R9", itype({6'b000000, 6'd4}, 3'd5, 5'd7, 7'b1011011), PAT, '0);

        // R8 / R9: register double-width ops, amount uses 6 bits
        run("R8", rtype(7'h00, 3'd0, 5'd8, 7'b1111011), PAT, PAT);
        run("R8", rtype(7'h20, 3'd0, 5'd8, 7'b1111011), 128'd0, 128'd1);
        run("R8", rtype(7'h00, 3'd1, 5'd8, 7'b1111011), PAT, 128'd69);
        run("R8", rtype(7'h00, 3'd5, 5'd8, 7'b1111011), PAT, 128'd64);
        run("R9", rtype(7'h20, 3'd5, 5'd8, 7'b1111011), {64'd0, 64'h8000_0000_0000_0000}, 128'd3);

        // R10: word ops
        run("R10", rtype(7'h00, 3'd0, 5'd9, 7'b0111011), 128'h7FFF_FFFF, 128'd1);
        run("R10", rtype(7'h20, 3'd0, 5'd9, 7'b0111011), 128'd0, 128'd1);
        run("R10", rtype(7'h00, 3'd1, 5'd9, 7'b0111011), PAT, 128'd36);
        run("R10", rtype(7'h00, 3'd5, 5'd9, 7'b0111011), 128'h8000_0000, 128'd32);
        run("R10", rtype(7'h20, 3'd5, 5'd9, 7'b0111011), 128'h8000_0000, 128'd4);
        run("R10", itype(12'h800, 3'd0, 5'd9, 7'b0011011), PAT, '0);
        run("R10", itype({7'h00, 5'd31}, 3'd1, 5'd9, 7'b0011011), 128'd1, '0);
        run("R10", itype({7'h00, 5'd1}, 3'd5, 5'd9, 7'b0011011), 128'hFFFF_FFFF, '0);
        run("R10", itype({7'h20, 5'd8}, 3'd5, 5'd9, 7'b0011011), 128'h8000_0000, '0);

        // R11: destination zero
        run("R11", itype(12'h005, 3'd0, 5'd0, 7'b0010011), 128'd1, '0);
        run("R11", rtype(7'h00, 3'd0, 5'd0, 7'b1111011), 128'd1, 128'd1);

        // R12: unrecognised words
        run("R12", 32'h0000_0000, PAT, PAT);
        run("R12", rtype(7'h01, 3'd0, 5'd10, 7'b0110011), PAT, PAT);
        run("R12", itype(12'h000, 3'd2, 5'd10, 7'b1011011), PAT, PAT);
        run("R12", itype({6'b100000, 6'd1}, 3'd5, 5'd10, 7'b1011011), PAT, PAT);
        run("R12", rtype(7'h20, 3'd1, 5'd10, 7'b0111011), PAT, PAT);
        run("R12", itype({5'b00001, 7'd3}, 3'd1, 5'd10, 7'b0010011), PAT, PAT);

        // Random stream over all major opcodes
        for (int n = 0; n < 400; n++) begin
            logic [31:0] ri;
            logic [6:0]  op;
            case ($urandom_range(0, 6))
                0: op = 7'b0110011;
                1: op = 7'b0010011;
                2: op = 7'b0111011;
                3: op = 7'b0011011;
                4: op = 7'b1111011;
                5: op = 7'b1011011;
                default: op = 7'($urandom);
            endcase
            ri = $urandom;
            if ($urandom_range(0, 1) == 0) ri[31:25] = ($urandom_range(0, 1) == 0) ? 7'h00 : 7'h20;
            ri[6:0] = op;
            run("RND", ri, {$urandom, $urandom, $urandom, $urandom},
                {$urandom, $urandom, $urandom, $urandom});
        end

        finish_run();
    end

endmodule